// File: doc/BRIEF.md
# 8b/10b Line Encoder with Running Disparity

This block turns a stream of data bytes into 10-bit symbols with a bounded DC level, one byte for each cycle on which the input is marked valid. The low five bits of the byte pass through a 5-bit-to-6-bit mapping. The high three bits pass through a 3-bit-to-4-bit mapping. Each mapping gives a base code. A shared balance stage then either keeps that code or inverts every bit of it, depending on the current running disparity. Only one form of each code is stored. The other form is derived by the inversion.

The running disparity lives in a two-state machine with states `RD_MINUS` and `RD_PLUS`. It leaves reset in `RD_MINUS`. On each valid cycle it takes one of two named transitions. It takes `hold` when the symbol carries five ones. It takes `flip` when the symbol carries four or six ones. On invalid cycles it always takes `hold`. The 6-bit stage sees the disparity at the start of the symbol. The 4-bit stage sees the disparity left over after the 6-bit sub-block. The result is registered and appears one cycle after the byte arrives. Only data characters are encoded.

Top module: `line_enc8b10b`

## Requirements
- R1: While reset is held, `symbol_out` is 0 and `symbol_valid` is 0. After reset the disparity state is `RD_MINUS`, so a first byte of 0x00 encodes to 10'b1001110100.
- R2: A byte presented with `data_valid` high appears on `symbol_out` one clock later, with `symbol_valid` high in that cycle. `symbol_valid` is low in the cycle after `data_valid` was low.
- R3: `symbol_out[9:4]` holds the 6-bit code of `data_in[4:0]` and `symbol_out[3:0]` holds the 4-bit code of `data_in[7:5]`. Bit 9 is the first bit on the line and bit 0 the last.
- R4: The 6-bit base forms are written with the leftmost digit at `symbol_out[9]`. They include 0→100111, 3→110001, 7→111000 and 23→111010.
- R5: The 4-bit base forms are written with the leftmost digit at `symbol_out[3]`. They include 0→1011, 3→1100 and 5→1010.
- R6: A sub-block with equal ones and zeros is emitted as its base form in either disparity state, and it leaves the disparity unchanged. For example, byte 0x63 encodes to 10'b1100011100 in `RD_PLUS`.
- R7: An unbalanced sub-block is emitted as its base form (more ones) in `RD_MINUS` and as the bitwise inverse in `RD_PLUS`. It then flips the disparity. For example, byte 0x07 in `RD_PLUS` gives 10'b1110000100.
- R8: The 4-bit stage chooses its form from the disparity after the 6-bit sub-block. For example, byte 0x00 in `RD_PLUS` gives 10'b0110001011, and byte 0x60 in `RD_MINUS` gives 10'b1001111100.
- R9: Every 6-bit sub-block holds 2 to 4 ones and every 4-bit sub-block holds 1 to 3 ones. An unbalanced sub-block is always the one that brings the running disparity from -1 to +1 or from +1 to -1, so it stays within ±2 and is ±1 at every symbol boundary.
- R10: Cycles with `data_valid` low change neither `symbol_out` nor the disparity state, whatever `data_in` carries.
- R11: Across both starting disparity states, no two different bytes produce the same 10-bit symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 8 | Byte to encode; bits [4:0] feed the 6-bit stage, bits [7:5] the 4-bit stage |
| data_valid | input | 1 | Marks `data_in` as a byte to encode this cycle |
| symbol_out | output | 10 | Registered 10-bit symbol, bit 9 first on the line |
| symbol_valid | output | 1 | High in the cycle after a valid byte |

## Verification
Fixed bytes are sent from a known disparity state and compared against exact symbols. The byte 0x00 sent from both states tells the inverted form from the base form. The byte 0x00 sent from negative also tells whether the 4-bit stage uses the mid-symbol disparity or the start-of-symbol disparity. The bytes 0x63 and 0x07 sent from positive separate balanced sub-blocks from unbalanced ones. Idle gaps carrying changing data show whether invalid cycles disturb the output or the disparity. A full sweep of all 256 bytes from each starting state is primed by a byte that flips the disparity, and each result is scored against a disparity model. This sweep confirms every sub-block weight, the sign of every flip, and that symbols are unique across both states.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;
    localparam int LO_W    = 5;
    localparam int HI_W    = 3;
    localparam int BYTE_W  = LO_W + HI_W;
    localparam int LO_CW   = LO_W + 1;
    localparam int HI_CW   = HI_W + 1;
    localparam int SYM_W   = LO_CW + HI_CW;

    typedef enum logic {
        RD_MINUS = 1'b0,
        RD_PLUS  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/line_enc_map6.sv
module line_enc_map6
    import line_enc_pkg::*;
(
    input  logic [LO_W-1:0]  grp_lo,
    output logic [LO_CW-1:0] base6
);
    // Base forms written a..i, leftmost bit first on the line; unbalanced
    // entries carry four ones.
    always_comb begin
        unique case (grp_lo)
            5'd0:  base6 = 6'b100111;
            5'd1:  base6 = 6'b011101;
            5'd2:  base6 = 6'b101101;
            5'd3:  base6 = 6'b110001;
            5'd4:  base6 = 6'b110101;
            5'd5:  base6 = 6'b101001;
            5'd6:  base6 = 6'b011001;
            5'd7:  base6 = 6'b111000;
            5'd8:  base6 = 6'b111001;
            5'd9:  base6 = 6'b100101;
            5'd10: base6 = 6'b010101;
            5'd11: base6 = 6'b110100;
            5'd12: base6 = 6'b001101;
            5'd13: base6 = 6'b101100;
            5'd14: base6 = 6'b011100;
            5'd15: base6 = 6'b010111;
            5'd16: base6 = 6'b011011;
            5'd17: base6 = 6'b100011;
            5'd18: base6 = 6'b010011;
            5'd19: base6 = 6'b110010;
            5'd20: base6 = 6'b001011;
            5'd21: base6 = 6'b101010;
            5'd22: base6 = 6'b011010;
            5'd23: base6 = 6'b111010;
            5'd24: base6 = 6'b110011;
            5'd25: base6 = 6'b100110;
            5'd26: base6 = 6'b010110;
            5'd27: base6 = 6'b110110;
            5'd28: base6 = 6'b001110;
            5'd29: base6 = 6'b101110;
            5'd30: base6 = 6'b011110;
            default: base6 = 6'b101011;
        endcase
    end
endmodule

// File: rtl/line_enc_map4.sv
module line_enc_map4
    import line_enc_pkg::*;
(
    input  logic [HI_W-1:0]  grp_hi,
    output logic [HI_CW-1:0] base4
);
    // Base forms written f..j; unbalanced entries carry three ones.
    always_comb begin
        unique case (grp_hi)
            3'd0:    base4 = 4'b1011;
            3'd1:    base4 = 4'b1001;
            3'd2:    base4 = 4'b0101;
            3'd3:    base4 = 4'b1100;
            3'd4:    base4 = 4'b1101;
            3'd5:    base4 = 4'b1010;
            3'd6:    base4 = 4'b0110;
            default: base4 = 4'b1110;
        endcase
    end
endmodule

// File: rtl/line_enc_balance.sv
module line_enc_balance
    import line_enc_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] base_code,
    input  rd_state_e    rd_in,
    output logic [W-1:0] code_out,
    output rd_state_e    rd_out
);
    localparam int HALF = W / 2;
    localparam int CW   = $clog2(W + 1);

    logic [CW-1:0] ones;
    logic          level;
    logic          heavy;
    logic          invert;

    // Ones counter: the weight of the base form.
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(base_code[i]);
        end
    end

    assign level  = (ones == CW'(HALF));
    assign heavy  = (ones > CW'(HALF));
    // Pick the form that pushes disparity toward the opposite sign.
    assign invert = !level && ((rd_in == RD_MINUS) ? !heavy : heavy);

    assign code_out = base_code ^ {W{invert}};

    always_comb begin
        if (level) begin
            rd_out = rd_in;
        end else begin
            rd_out = (rd_in == RD_MINUS) ? RD_PLUS : RD_MINUS;
        end
    end
endmodule

// File: rtl/line_enc8b10b.sv
module line_enc8b10b
    import line_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        data_in,
    input  logic              data_valid,
    output logic [9:0]        symbol_out,
    output logic              symbol_valid
);
    rd_state_e          rd_q;
    rd_state_e          rd_d;
    rd_state_e          rd_mid;
    rd_state_e          rd_end;
    logic [LO_CW-1:0]   base6;
    logic [HI_CW-1:0]   base4;
    logic [LO_CW-1:0]   code6;
    logic [HI_CW-1:0]   code4;
    logic [SYM_W-1:0]   sym_q;
    logic               vld_q;
    logic               rd_pos;

    line_enc_map6 u_map6 (
        .grp_lo (data_in[LO_W-1:0]),
        .base6  (base6)
    );

    line_enc_map4 u_map4 (
        .grp_hi (data_in[BYTE_W-1:LO_W]),
        .base4  (base4)
    );

    // Both sub-blocks share one balance stage, sized per width; the 4-bit
    // stage is chained on the disparity left by the 6-bit stage.
    line_enc_balance #(.W(LO_CW)) u_bal6 (
        .base_code (base6),
        .rd_in     (rd_q),
        .code_out  (code6),
        .rd_out    (rd_mid)
    );

    line_enc_balance #(.W(HI_CW)) u_bal4 (
        .base_code (base4),
        .rd_in     (rd_mid),
        .code_out  (code4),
        .rd_out    (rd_end)
    );

    // Disparity state: hold on idle or net-balanced symbols, flip otherwise.
    always_comb begin
        unique case (rd_q)
            RD_MINUS: rd_d = data_valid ? rd_end : RD_MINUS;
            RD_PLUS:  rd_d = data_valid ? rd_end : RD_PLUS;
            default:  rd_d = RD_MINUS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= RD_MINUS;
        end else begin
            rd_q <= rd_d;
        end
    end

    // Output register: one cycle of latency, held while idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= data_valid;
            if (data_valid) begin
                sym_q <= {code6, code4};
            end
        end
    end

    assign rd_pos       = (rd_q == RD_PLUS);
    assign symbol_out   = sym_q;
    assign symbol_valid = vld_q;
endmodule

// File: rtl/line_enc8b10b_chk.sv
module line_enc8b10b_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       data_valid,
    input logic       symbol_valid,
    input logic [9:0] symbol_out,
    input logic       rd_pos
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> symbol_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |=> !symbol_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |=> ($stable(symbol_out) && $stable(rd_pos)));

    // R9
    six_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        symbol_valid |-> ($countones(symbol_out[9:4]) >= 2 && $countones(symbol_out[9:4]) <= 4));

    // R9
    four_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        symbol_valid |-> ($countones(symbol_out[3:0]) >= 1 && $countones(symbol_out[3:0]) <= 3));

    // R7
    neg_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !rd_pos) |=> ($countones(symbol_out) >= 5));

    // R7
    pos_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && rd_pos) |=> ($countones(symbol_out) <= 5));

    // R6
    rd_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> (($countones(symbol_out) == 5) == (rd_pos == $past(rd_pos))));
endmodule

bind line_enc8b10b line_enc8b10b_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_valid   (data_valid),
    .symbol_valid (symbol_valid),
    .symbol_out   (symbol_out),
    .rd_pos       (rd_pos)
);

// File: tb/line_enc8b10b_bench.sv
`timescale 1ns/1ps
module line_enc8b10b_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       data_valid = 1'b0;
    logic [9:0] symbol_out;
    logic       symbol_valid;

    int checks = 0;
    int errors = 0;
    int mrd = -1;
    bit done = 1'b0;
    int owner [1024];

    always #10 clk = ~clk;

    line_enc8b10b u_line_enc8b10b (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_in      (data_in),
        .data_valid   (data_valid),
        .symbol_out   (symbol_out),
        .symbol_valid (symbol_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Disparity model per sub-block (R9).
    task automatic track(input logic [9:0] code);
        int o6, o4;
        bit ok;
        ok = 1'b1;
        o6 = $countones(code[9:4]);
        o4 = $countones(code[3:0]);
        if (o6 == 4) begin ok = ok && (mrd == -1); mrd = 1; end
        else if (o6 == 2) begin ok = ok && (mrd == 1); mrd = -1; end
        else if (o6 != 3) ok = 1'b0;
        if (o4 == 3) begin ok = ok && (mrd == -1); mrd = 1; end
        else if (o4 == 1) begin ok = ok && (mrd == 1); mrd = -1; end
        else if (o4 != 2) ok = 1'b0;
        chk(ok, "R9 sub-block weight/disparity", code, code);
    endtask

    task automatic send(input logic [7:0] b, output logic [9:0] code);
        @(negedge clk);
        data_in = b;
        data_valid = 1'b1;
        @(negedge clk);
        data_valid = 1'b0;
        code = symbol_out;
        track(code);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        data_valid = 1'b0;
        mrd = -1;
        repeat (3) @(negedge clk);
        chk(symbol_out == 10'd0, "R1 reset symbol", symbol_out, 10'd0);
        chk(symbol_valid == 1'b0, "R1 reset valid", {9'd0, symbol_valid}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_first_after_reset();
        logic [9:0] c;
        do_reset();
        send(8'h00, c);
        chk(c == 10'b1001110100, "R1 first symbol from RD_MINUS", c, 10'b1001110100);
    endtask

    task automatic t_handshake();
        logic [9:0] c;
        @(negedge clk);
        data_in = 8'hB7;
        data_valid = 1'b1;
        #1;
        chk(symbol_valid == 1'b0, "R2 no same-cycle valid", {9'd0, symbol_valid}, 10'd0);
        @(negedge clk);
        data_valid = 1'b0;
        chk(symbol_valid == 1'b1, "R2 valid after one cycle", {9'd0, symbol_valid}, 10'd1);
        c = symbol_out;
        track(c);
        // R3 R4 R5: 23 -> 111010, 5 -> 1010
        chk(c == 10'b1110101010, "R3 field layout", c, 10'b1110101010);
        @(negedge clk);
        chk(symbol_valid == 1'b0, "R2 valid drops", {9'd0, symbol_valid}, 10'd0);
    endtask

    task automatic t_exact();
        logic [9:0] c;
        do_reset();
        send(8'h60, c);
        chk(c == 10'b1001111100, "R8 0x60 from RD_MINUS", c, 10'b1001111100);
        send(8'h63, c);
        chk(c == 10'b1100011100, "R6 balanced 0x63 in RD_PLUS", c, 10'b1100011100);
        send(8'h00, c);
        chk(c == 10'b0110001011, "R8 0x00 in RD_PLUS", c, 10'b0110001011);
        send(8'h07, c);
        chk(c == 10'b1110000100, "R7 0x07 in RD_PLUS", c, 10'b1110000100);
        send(8'h00, c);
        chk(c == 10'b1001110100, "R4 0x00 in RD_MINUS", c, 10'b1001110100);
    endtask

    task automatic t_idle_hold();
        logic [9:0] c, held;
        do_reset();
        send(8'h60, c);
        held = c;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            data_in = 8'(k * 37 + 1);
            data_valid = 1'b0;
            @(negedge clk);
            chk(symbol_out == held, "R10 idle output held", symbol_out, held);
        end
        send(8'h00, c);
        chk(c == 10'b0110001011, "R10 disparity kept over idle", c, 10'b0110001011);
    endtask

    task automatic t_sweep();
        logic [9:0] c;
        bit clash;
        clash = 1'b0;
        do_reset();
        for (int i = 0; i < 1024; i++) owner[i] = -1;
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 256; b++) begin
                if (mrd != ((s == 0) ? -1 : 1)) send(8'h60, c);
                send(8'(b), c);
                if (owner[c] != -1 && owner[c] != b) begin
                    clash = 1'b1;
                    chk(1'b0, "R11 duplicate symbol", c, 10'(owner[c]));
                end
                owner[c] = b;
            end
        end
        chk(!clash, "R11 symbols unique over both states", 10'd0, 10'd0);
    endtask

    initial begin
        t_first_after_reset();
        t_handshake();
        t_exact();
        t_idle_hold();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule